// File: doc/BRIEF.md
# GPIO Bank Event Detector with Interrupt and Wake Outputs

This block watches a bank of general-purpose input pins and turns pin activity into latched events. For every pin, software chooses between edge detection and level detection. In edge mode the pin can react to a rising transition, a falling transition or both. In level mode the pin reacts to a chosen active level, high or low. Each detected event sets a sticky bit in an interrupt status register and a sticky bit in a wake status register. Software clears either bit by writing a one to it.

A per-pin interrupt enable selects which latched status bits drive the single combined interrupt line. A separate per-pin wake enable selects which latched wake bits drive the wake request line. Configuration and status are reached through a simple word-wide register port. Writes take one clock to land, and reads are combinational. Pin inputs are assumed to be already synchronised to the block clock.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset, every register reads zero and both `irq` and `wake_req` are low. With the edge enables at zero, no pin activity produces an event.
- R2: A pin in edge mode (type bit 0) with its rising enable (offset 0x064) set latches its interrupt status bit (offset 0x0C4) in the clock where the pin is first sampled high after being low.
- R3: A pin whose falling enable (offset 0x07C) is set latches on a high-to-low transition. When both enables are set, the pin latches on either transition.
- R4: A type bit of 1 (offset 0x300) selects level mode. The pin then latches while it is high if its polarity bit (offset 0x318) is 0, and while it is low if the polarity bit is 1. The edge enables have no effect in level mode.
- R5: In level mode the status bit is set again on every clock while the active level persists, so a write-one clear does not keep it cleared.
- R6: Writing to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. An event in the same cycle as a clear of the same bit leaves the bit set.
- R7: `irq` is high exactly when some status bit and its interrupt enable bit (offset 0x0AC, 1 = enabled) are both 1.
- R8: Every detected event also sets the pin's wake status bit (offset 0x418), whatever the interrupt enable says. That bit is cleared by writing one to it. `wake_req` is high exactly when some wake status bit and its wake enable bit (offset 0x400) are both 1.
- R9: The six configuration registers read back the value last written. A read of any other offset returns zero.
- R10: A status bit is set only by a detected event. A pin whose selected detection does not fire leaves its bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Synchronised pin levels |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined enabled interrupt |
| wake_req | output | 1 | Combined enabled wake request |

## Verification
A pin level presented before a rising clock edge is judged at that edge. Its status and wake bits, and therefore `irq` and `wake_req`, change in the cycle after that edge. A configuration or clear write presented before an edge takes effect at the same edge, so detection uses the new setting from the following cycle onward.

The bench drives pins and writes at the falling edge. It samples the outputs and makes combinational register reads shortly after the next rising edge. At that point the bench's arithmetic model has already absorbed exactly that edge.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int ADDR_W = 12;

  // Register byte offsets decoded by software
  localparam logic [ADDR_W-1:0] OFS_RISE  = 12'h064;
  localparam logic [ADDR_W-1:0] OFS_FALL  = 12'h07C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h0AC;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h0C4;
  localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_POL   = 12'h318;
  localparam logic [ADDR_W-1:0] OFS_WMASK = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_WSTAT = 12'h418;

  typedef enum logic [2:0] {
    CFG_RISE  = 3'd0,
    CFG_FALL  = 3'd1,
    CFG_MASK  = 3'd2,
    CFG_TYPE  = 3'd3,
    CFG_POL   = 3'd4,
    CFG_WMASK = 3'd5,
    CFG_NONE  = 3'd7
  } cfg_sel_e;

  localparam int NCFG = 6;

  function automatic cfg_sel_e cfg_decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_RISE:  return CFG_RISE;
      OFS_FALL:  return CFG_FALL;
      OFS_MASK:  return CFG_MASK;
      OFS_TYPE:  return CFG_TYPE;
      OFS_POL:   return CFG_POL;
      OFS_WMASK: return CFG_WMASK;
      default:   return CFG_NONE;
    endcase
  endfunction

  // One pin's detection decision for the current cycle
  function automatic logic pin_event(input logic cur, input logic prev,
                                     input logic rise_en, input logic fall_en,
                                     input logic is_level, input logic low_active);
    logic edge_hit;
    logic lvl_hit;
    edge_hit = (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
    lvl_hit  = cur ^ low_active;
    return is_level ? lvl_hit : edge_hit;
  endfunction

  // Sticky bit update: a set wins over a clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
  import gpio_evt_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   rise_en,
  output logic [NPIN-1:0]   fall_en,
  output logic [NPIN-1:0]   int_mask,
  output logic [NPIN-1:0]   lvl_type,
  output logic [NPIN-1:0]   lvl_pol,
  output logic [NPIN-1:0]   wake_mask
);

  cfg_sel_e          sel;
  logic [NPIN-1:0]   cfg_q [NCFG];

  assign sel = cfg_decode(bus_addr);

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (bus_wr && (int'(sel) == g)) begin
        cfg_q[g] <= bus_wdata;
      end
    end
  end

  assign rise_en   = cfg_q[int'(CFG_RISE)];
  assign fall_en   = cfg_q[int'(CFG_FALL)];
  assign int_mask  = cfg_q[int'(CFG_MASK)];
  assign lvl_type  = cfg_q[int'(CFG_TYPE)];
  assign lvl_pol   = cfg_q[int'(CFG_POL)];
  assign wake_mask = cfg_q[int'(CFG_WMASK)];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] lvl_type,
  input  logic [NPIN-1:0] lvl_pol,
  output logic [NPIN-1:0] evt
);

  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_in;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign evt[i] = pin_event(pin_in[i], prev_q[i], rise_en[i], fall_en[i],
                              lvl_type[i], lvl_pol[i]);
  end

endmodule

// File: rtl/gpio_evt_sticky.sv
module gpio_evt_sticky
  import gpio_evt_pkg::*;
#(
  parameter int                NPIN    = 32,
  parameter logic [ADDR_W-1:0] CLR_OFS = OFS_STAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  input  logic [NPIN-1:0]   evt,
  output logic [NPIN-1:0]   st
);

  logic [NPIN-1:0] clr;

  assign clr = (bus_wr && (bus_addr == CLR_OFS)) ? bus_wdata : '0;

  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= 1'b0;
      else        st[i] <= sticky_next(st[i], evt[i], clr[i]);
    end
  end

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
  import gpio_evt_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  output logic              irq,
  output logic              wake_req
);

  logic [NPIN-1:0] cfg_rise, cfg_fall, cfg_mask, cfg_type, cfg_pol, cfg_wmask;
  logic [NPIN-1:0] det_evt;
  logic [NPIN-1:0] int_st;
  logic [NPIN-1:0] wake_st;

  gpio_evt_cfg #(.NPIN(NPIN)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rise_en   (cfg_rise),
    .fall_en   (cfg_fall),
    .int_mask  (cfg_mask),
    .lvl_type  (cfg_type),
    .lvl_pol   (cfg_pol),
    .wake_mask (cfg_wmask)
  );

  gpio_evt_detect #(.NPIN(NPIN)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .rise_en  (cfg_rise),
    .fall_en  (cfg_fall),
    .lvl_type (cfg_type),
    .lvl_pol  (cfg_pol),
    .evt      (det_evt)
  );

  gpio_evt_sticky #(.NPIN(NPIN), .CLR_OFS(OFS_STAT)) u_int_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt       (det_evt),
    .st        (int_st)
  );

  gpio_evt_sticky #(.NPIN(NPIN), .CLR_OFS(OFS_WSTAT)) u_wake_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt       (det_evt),
    .st        (wake_st)
  );

  always_comb begin
    case (bus_addr)
      OFS_RISE:  bus_rdata = cfg_rise;
      OFS_FALL:  bus_rdata = cfg_fall;
      OFS_MASK:  bus_rdata = cfg_mask;
      OFS_STAT:  bus_rdata = int_st;
      OFS_TYPE:  bus_rdata = cfg_type;
      OFS_POL:   bus_rdata = cfg_pol;
      OFS_WMASK: bus_rdata = cfg_wmask;
      OFS_WSTAT: bus_rdata = wake_st;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq      = |(int_st & cfg_mask);
  assign wake_req = |(wake_st & cfg_wmask);

endmodule

// File: rtl/gpio_evt_unit_chk.sv
module gpio_evt_unit_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] pin_in,
  input logic [NPIN-1:0] det_evt,
  input logic [NPIN-1:0] int_st,
  input logic [NPIN-1:0] wake_st,
  input logic [NPIN-1:0] int_mask,
  input logic [NPIN-1:0] wake_mask,
  input logic [NPIN-1:0] lvl_type,
  input logic [NPIN-1:0] lvl_pol,
  input logic            irq,
  input logic            wake_req
);

  AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (det_evt != '0) |=> ((int_st & $past(det_evt)) == $past(det_evt))); // R6

  AST_EVT_SETS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (det_evt != '0) |=> ((wake_st & $past(det_evt)) == $past(det_evt))); // R8

  AST_STATUS_ONLY_BY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int_st & ~$past(int_st) & ~$past(det_evt)) == '0)); // R10

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((int_st & int_mask) != '0)); // R7

  AST_WAKE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ((wake_st & wake_mask) != '0)); // R8

  AST_LEVEL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_type & (pin_in ^ lvl_pol) & ~det_evt) == '0)); // R4

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_type & (pin_in ^ lvl_pol)) != '0)
      |=> ((int_st & $past(lvl_type & (pin_in ^ lvl_pol))) != '0)); // R5

endmodule

bind gpio_evt_unit gpio_evt_unit_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_in    (pin_in),
  .det_evt   (det_evt),
  .int_st    (int_st),
  .wake_st   (wake_st),
  .int_mask  (cfg_mask),
  .wake_mask (cfg_wmask),
  .lvl_type  (cfg_type),
  .lvl_pol   (cfg_pol),
  .irq       (irq),
  .wake_req  (wake_req)
);

// File: tb/gpio_evt_unit_tb.sv
module gpio_evt_unit_tb;
  import gpio_evt_pkg::*;

  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic          irq, wake_req;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of architectural state
  logic [NP-1:0] m_rise = '0, m_fall = '0, m_mask = '0, m_type = '0;
  logic [NP-1:0] m_pol = '0, m_wmask = '0, m_int = '0, m_wake = '0, m_prev = '0;

  always #4 clk = ~clk;

  gpio_evt_unit #(.NPIN(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake_req(wake_req)
  );

  task automatic chk(input string tag, input string what, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [NP-1:0] exp);
    bus_addr = a;
    #1;
    chk(tag, "read", bus_rdata, exp);
  endtask

  // One clock: drive at falling edge, update model at rising edge, then check
  task automatic tick(input logic [NP-1:0] pins, input logic wr, input logic [11:0] a,
                      input logic [NP-1:0] d, input string tag);
    logic [NP-1:0] edge_v, lvl_v, evt_v, clr_i, clr_w;
    @(negedge clk);
    pin_in = pins; bus_wr = wr; bus_addr = a; bus_wdata = d;
    edge_v = (m_rise & pins & ~m_prev) | (m_fall & m_prev & ~pins);
    lvl_v  = (pins & ~m_pol) | (~pins & m_pol);
    evt_v  = (m_type & lvl_v) | (~m_type & edge_v);
    clr_i  = (wr && a == OFS_STAT)  ? d : '0;
    clr_w  = (wr && a == OFS_WSTAT) ? d : '0;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    m_int  = evt_v | (m_int & ~clr_i);
    m_wake = evt_v | (m_wake & ~clr_w);
    m_prev = pins;
    if (wr) begin
      case (a)
        OFS_RISE:  m_rise  = d;
        OFS_FALL:  m_fall  = d;
        OFS_MASK:  m_mask  = d;
        OFS_TYPE:  m_type  = d;
        OFS_POL:   m_pol   = d;
        OFS_WMASK: m_wmask = d;
        default: ;
      endcase
    end
    chk(tag, "irq", {{(NP-1){1'b0}}, irq}, {{(NP-1){1'b0}}, |(m_int & m_mask)});
    chk(tag, "wake_req", {{(NP-1){1'b0}}, wake_req}, {{(NP-1){1'b0}}, |(m_wake & m_wmask)});
    rd_chk(tag, OFS_STAT, m_int);
    rd_chk(tag, OFS_WSTAT, m_wake);
  endtask

  task automatic idle(input logic [NP-1:0] pins, input string tag);
    tick(pins, 1'b0, 12'h000, '0, tag);
  endtask

  task automatic wr(input logic [NP-1:0] pins, input logic [11:0] a, input logic [NP-1:0] d,
                    input string tag);
    tick(pins, 1'b1, a, d, tag);
  endtask

  task automatic clean(input string tag);
    wr(m_prev, OFS_TYPE, '0, tag);
    wr(m_prev, OFS_RISE, '0, tag);
    wr(m_prev, OFS_FALL, '0, tag);
    wr(m_prev, OFS_POL, '0, tag);
    wr(m_prev, OFS_STAT, '1, tag);
    wr(m_prev, OFS_WSTAT, '1, tag);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    logic [11:0] offs [8];
    offs = '{OFS_RISE, OFS_FALL, OFS_MASK, OFS_STAT, OFS_TYPE, OFS_POL, OFS_WMASK, OFS_WSTAT};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    for (int k = 0; k < 8; k++) rd_chk("R1", offs[k], '0);
    chk("R1", "irq", {31'b0, irq}, '0);
    chk("R1", "wake_req", {31'b0, wake_req}, '0);
    idle('1, "R1");
    idle('0, "R1");

    // R9: config read-back and unmapped offsets
    wr('0, OFS_RISE,  32'h1234_5678, "R9");
    wr('0, OFS_FALL,  32'h8765_4321, "R9");
    wr('0, OFS_MASK,  32'hA5A5_0F0F, "R9");
    wr('0, OFS_TYPE,  32'h0000_FF00, "R9");
    wr('0, OFS_POL,   32'hF0F0_F0F0, "R9");
    wr('0, OFS_WMASK, 32'h5A5A_C3C3, "R9");
    rd_chk("R9", OFS_RISE,  32'h1234_5678);
    rd_chk("R9", OFS_FALL,  32'h8765_4321);
    rd_chk("R9", OFS_MASK,  32'hA5A5_0F0F);
    rd_chk("R9", OFS_TYPE,  32'h0000_FF00);
    rd_chk("R9", OFS_POL,   32'hF0F0_F0F0);
    rd_chk("R9", OFS_WMASK, 32'h5A5A_C3C3);
    rd_chk("R9", 12'h010, '0);
    wr('0, 12'h020, '1, "R9");
    rd_chk("R9", 12'h020, '0);
    clean("R9");
    wr('0, OFS_MASK, '0, "R9");
    wr('0, OFS_WMASK, '0, "R9");

    // R2 / R3: edge sweep per pin and mode
    for (int p = 0; p < NP; p++) begin
      for (int md = 1; md < 4; md++) begin
        string tg;
        tg = (md == 1) ? "R2" : "R3";
        wr('0, OFS_RISE, md[0] ? (32'd1 << p) : '0, tg);
        wr('0, OFS_FALL, md[1] ? (32'd1 << p) : '0, tg);
        wr('0, OFS_MASK, 32'd1 << p, tg);
        wr('0, OFS_WMASK, (p % 2 == 0) ? (32'd1 << p) : '0, tg);
        idle(32'd1 << p, tg);
        idle(32'd1 << p, tg);
        wr(32'd1 << p, OFS_STAT, '1, tg);
        idle('0, tg);
        wr('0, OFS_STAT, '1, tg);
        wr('0, OFS_WSTAT, '1, tg);
      end
    end
    clean("R2");

    // R4 / R5: level sweep with both polarities and edge enables set
    wr('0, OFS_RISE, '1, "R4");
    wr('0, OFS_FALL, '1, "R4");
    for (int p = 0; p < NP; p += 3) begin
      for (int pl = 0; pl < 2; pl++) begin
        logic [NP-1:0] act;
        act = pl[0] ? '0 : (32'd1 << p);
        wr(~act & (32'd1 << p), OFS_POL, pl[0] ? (32'd1 << p) : '0, "R4");
        wr(~act & (32'd1 << p), OFS_TYPE, '1, "R4");
        wr(~act & (32'd1 << p), OFS_STAT, '1, "R4");
        wr(~act & (32'd1 << p), OFS_WSTAT, '1, "R4");
        idle(act, "R4");
        wr(act, OFS_STAT, '1, "R5");
        idle(act, "R5");
        wr(act, OFS_STAT, 32'd1 << p, "R5");
        chk("R5", "level bit held", m_int & (32'd1 << p), 32'd1 << p);
        wr(m_prev, OFS_TYPE, '0, "R4");
      end
    end
    clean("R4");

    // R6: clear semantics and set priority
    wr('0, OFS_RISE, 32'h0000_0003, "R6");
    idle(32'h0000_0003, "R6");
    wr(32'h0000_0003, OFS_STAT, 32'h0000_0002, "R6");
    rd_chk("R6", OFS_STAT, 32'h0000_0001);
    wr('0, OFS_STAT, 32'h0, "R6");
    rd_chk("R6", OFS_STAT, 32'h0000_0001);
    wr(32'h0000_0001, OFS_STAT, 32'h0000_0001, "R6");
    rd_chk("R6", OFS_STAT, 32'h0000_0001);

    // R7: interrupt gating by mask
    wr(m_prev, OFS_MASK, '0, "R7");
    chk("R7", "irq masked", {31'b0, irq}, '0);
    wr(m_prev, OFS_MASK, 32'h0000_0001, "R7");
    chk("R7", "irq enabled", {31'b0, irq}, 32'd1);
    wr(m_prev, OFS_STAT, '1, "R7");
    chk("R7", "irq after clear", {31'b0, irq}, '0);

    // R8: wake status independent of interrupt mask
    wr(m_prev, OFS_MASK, '0, "R8");
    wr(m_prev, OFS_WMASK, '0, "R8");
    idle('0, "R8");
    idle(32'h0000_0002, "R8");
    rd_chk("R8", OFS_WSTAT, m_wake);
    wr(m_prev, OFS_WMASK, 32'h0000_0002, "R8");
    chk("R8", "wake_req", {31'b0, wake_req}, 32'd1);
    wr(m_prev, OFS_WSTAT, 32'h0000_0002, "R8");
    chk("R8", "wake_req cleared", {31'b0, wake_req}, '0);
    clean("R8");

    // R10: random pins and configuration
    for (int n = 0; n < 2000; n++) begin
      logic [NP-1:0] pv;
      pv = $urandom;
      if ($urandom_range(0, 3) == 0) begin
        wr(pv, offs[$urandom_range(0, 7)], $urandom & $urandom, "R10");
      end else begin
        idle(pv, "R10");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule